// File: doc/BRIEF.md
# Peripheral Idle Timer and Access Trap Unit

This unit watches I/O bus traffic on behalf of six local peripherals: a disk controller, an audio device, a serial port and three slots that software assigns freely. Each peripheral owns an address window, a 16-bit idle countdown with its own reload value, an idle-timing enable and a trap enable. Every bus access is compared against all six windows in parallel. A hit reloads that peripheral's countdown. When the trap enable is set, the hit is also recorded as a trapped access.

A shared prescaled tick decrements every enabled countdown unless the global freeze bit is set. A countdown that reaches zero marks its peripheral, and a global idle flag, as requesting standby. Software then powers the device down, turns its idle timing off and turns trapping on, so the next access to the sleeping device raises the system-management interrupt in the same cycle as that access. The interrupt line is the OR of all pending status that its global enables let through. Software clears status by writing ones.

Top module: `pidle_trap_unit`

## Requirements
- R1: After reset every register reads as zero and `smi` is low.
- R2: A device's count drops by one on each cycle with `tick` high, but only while its bit in the idle-enable register (address 1, bits 5:0) is set and the freeze bit (CTRL address 0, bit 0) is clear. The count reads back in bits 31:16 of the device's reload register (address 16+d).
- R3: An access with `io_valid` high hits device d when base <= `io_addr` <= base+size-1. The window register is at address 8+d, with the base in bits 15:0 and the size in bits 31:16. A size of zero never hits. A hit loads the count from the reload value, and this load takes priority over a tick in the same cycle.
- R4: Writing the reload register (address 16+d, reload value in bits 15:0) stores the reload value and loads the count with the same value in the same edge.
- R5: A tick that takes a count from 1 to 0 sets, at that edge, both the device's idle status bit (STATUS address 3, bit d) and the global idle bit (bit 8). The count then stays at 0 until a hit or a reload write.
- R6: While the idle interrupt enable (CTRL bit 1) is set, `smi` is high whenever any idle status bit is set. With both interrupt enables clear, `smi` stays low.
- R7: A hit on a device whose bit in the trap-enable register (address 2, bits 5:0) is set raises `smi` in the same cycle as the access when CTRL bit 2 is set. From the next edge it sets the device's trap status bit (STATUS bit 16+d) and the global trap bit (bit 24).
- R8: Writing ones to STATUS clears the matching bits and writing zeros has no effect. A status event in the same cycle as its clear wins. `smi` falls once no enabled status remains.
- R9: A hit on a device whose trap enable is clear sets no trap status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Shared prescaled countdown strobe |
| io_valid | input | 1 | Bus I/O access present this cycle |
| io_addr | input | 16 | Bus I/O address |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| smi | output | 1 | System-management interrupt request |

## Verification
The collisions that matter are a countdown reaching its final tick while an access hits the same window, and a trap event landing in the cycle where software write-one-clears that same status bit. Both are driven on purpose in directed steps, and the random phase produces them often, because its windows are small, its reload values are small and its accesses cluster around the window edges. A bench reference model settles each collision in the required order: reload over decrement, and set over clear. The count, the status and `smi` are compared against that model on every cycle.

// File: rtl/pidle_pkg.sv
`timescale 1ns/1ps
package pidle_pkg;
    localparam int REG_AW = 5;
    localparam int REG_DW = 32;
    localparam int HALF_W = REG_DW / 2;

    // register addresses
    localparam logic [REG_AW-1:0] A_CTRL = 5'd0;
    localparam logic [REG_AW-1:0] A_IEN  = 5'd1;
    localparam logic [REG_AW-1:0] A_TEN  = 5'd2;
    localparam logic [REG_AW-1:0] A_STAT = 5'd3;
    localparam logic [REG_AW-1:0] A_WIN0 = 5'd8;
    localparam logic [REG_AW-1:0] A_RLD0 = 5'd16;

    // status word bit positions
    localparam int ST_GIDLE = 8;
    localparam int ST_TRAP0 = 16;
    localparam int ST_GTRAP = 24;

    typedef struct packed {
        logic trap_irq_en;
        logic idle_irq_en;
        logic freeze;
    } ctrl_t;
endpackage

// File: rtl/pidle_win_match.sv
`timescale 1ns/1ps
module pidle_win_match #(
    parameter int AW = 16
) (
    input  logic          valid,
    input  logic [AW-1:0] addr,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    output logic          hit
);
    logic [AW:0] offset;

    always_comb begin
        offset = {1'b0, addr} - {1'b0, base};
        hit    = valid && (size != '0) && (addr >= base) && (offset < {1'b0, size});
    end
endmodule

// File: rtl/pidle_countdown.sv
`timescale 1ns/1ps
module pidle_countdown #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          run,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic [TW-1:0] count,
    output logic          expire
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d  = tmr_q;
        expire = run && tick && !load && (tmr_q.cnt == TW'(1));
        if (load) begin
            tmr_d.cnt = load_val;
        end else if (run && tick && (tmr_q.cnt != '0)) begin
            tmr_d.cnt = tmr_q.cnt - TW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign count = tmr_q.cnt;
endmodule

// File: rtl/pidle_smi_gen.sv
`timescale 1ns/1ps
module pidle_smi_gen #(
    parameter int NDEV = 6
) (
    input  logic            idle_irq_en,
    input  logic            trap_irq_en,
    input  logic [NDEV-1:0] idle_st,
    input  logic            g_idle,
    input  logic [NDEV-1:0] trap_st,
    input  logic            g_trap,
    input  logic [NDEV-1:0] trap_now,
    output logic            smi
);
    logic idle_pend, trap_pend;

    always_comb begin
        idle_pend = g_idle || (|idle_st);
        trap_pend = g_trap || (|trap_st) || (|trap_now);
        smi       = (idle_irq_en && idle_pend) || (trap_irq_en && trap_pend);
    end
endmodule

// File: rtl/pidle_trap_unit.sv
`timescale 1ns/1ps
module pidle_trap_unit
    import pidle_pkg::*;
#(
    parameter int NDEV = 6,
    parameter int AW   = 16,
    parameter int TW   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              io_valid,
    input  logic [AW-1:0]     io_addr,
    input  logic              reg_wr,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [REG_DW-1:0] reg_wdata,
    output logic [REG_DW-1:0] reg_rdata,
    output logic              smi
);
    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        ctrl_t                      ctrl;
        logic [NDEV-1:0]            idle_en;
        logic [NDEV-1:0]            trap_en;
        logic [NDEV-1:0]            idle_st;
        logic [NDEV-1:0]            trap_st;
        logic                       g_idle;
        logic                       g_trap;
        logic [NDEV-1:0][AW-1:0]    base;
        logic [NDEV-1:0][AW-1:0]    size;
        logic [NDEV-1:0][TW-1:0]    reload;
    } regs_t;

    regs_t st_d, st_q;

    logic [NDEV-1:0]         hit;
    logic [NDEV-1:0]         expire;
    logic [NDEV-1:0]         trap_now;
    logic [NDEV-1:0]         wr_win;
    logic [NDEV-1:0]         wr_rld;
    logic [NDEV-1:0]         tmr_load;
    logic [NDEV-1:0]         tmr_run;
    logic [NDEV-1:0][TW-1:0] tmr_val;
    logic [NDEV-1:0][TW-1:0] cnt;
    logic                    wr_stat;

    // per-device window compare and countdown
    for (genvar g = 0; g < NDEV; g++) begin : g_dev
        pidle_win_match #(.AW(AW)) u_match (
            .valid (io_valid),
            .addr  (io_addr),
            .base  (st_q.base[g]),
            .size  (st_q.size[g]),
            .hit   (hit[g])
        );

        pidle_countdown #(.TW(TW)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (tick),
            .run      (tmr_run[g]),
            .load     (tmr_load[g]),
            .load_val (tmr_val[g]),
            .count    (cnt[g]),
            .expire   (expire[g])
        );
    end

    pidle_smi_gen #(.NDEV(NDEV)) u_smi (
        .idle_irq_en (st_q.ctrl.idle_irq_en),
        .trap_irq_en (st_q.ctrl.trap_irq_en),
        .idle_st     (st_q.idle_st),
        .g_idle      (st_q.g_idle),
        .trap_st     (st_q.trap_st),
        .g_trap      (st_q.g_trap),
        .trap_now    (trap_now),
        .smi         (smi)
    );

    // next-state computation
    always_comb begin
        st_d     = st_q;
        wr_stat  = reg_wr && (reg_addr == A_STAT);
        trap_now = hit & st_q.trap_en;

        for (int i = 0; i < NDEV; i++) begin
            wr_win[i]   = reg_wr && (reg_addr == A_WIN0 + REG_AW'(i));
            wr_rld[i]   = reg_wr && (reg_addr == A_RLD0 + REG_AW'(i));
            tmr_load[i] = wr_rld[i] || hit[i];
            tmr_val[i]  = wr_rld[i] ? TW'(reg_wdata[HALF_W-1:0]) : st_q.reload[i];
            tmr_run[i]  = st_q.idle_en[i] && !st_q.ctrl.freeze;
        end

        // write-one-to-clear, then new events win
        if (wr_stat) begin
            st_d.idle_st = st_q.idle_st & ~reg_wdata[NDEV-1:0];
            st_d.g_idle  = st_q.g_idle  & ~reg_wdata[ST_GIDLE];
            st_d.trap_st = st_q.trap_st & ~reg_wdata[ST_TRAP0 +: NDEV];
            st_d.g_trap  = st_q.g_trap  & ~reg_wdata[ST_GTRAP];
        end
        st_d.idle_st = st_d.idle_st | expire;
        st_d.trap_st = st_d.trap_st | trap_now;
        if (|expire)   st_d.g_idle = 1'b1;
        if (|trap_now) st_d.g_trap = 1'b1;

        if (reg_wr) begin
            case (reg_addr)
                A_CTRL:  st_d.ctrl    = ctrl_t'(reg_wdata[CTRL_W-1:0]);
                A_IEN:   st_d.idle_en = reg_wdata[NDEV-1:0];
                A_TEN:   st_d.trap_en = reg_wdata[NDEV-1:0];
                default: ;
            endcase
        end

        for (int i = 0; i < NDEV; i++) begin
            if (wr_win[i]) begin
                st_d.base[i] = AW'(reg_wdata[HALF_W-1:0]);
                st_d.size[i] = AW'(reg_wdata[REG_DW-1:HALF_W]);
            end
            if (wr_rld[i]) begin
                st_d.reload[i] = TW'(reg_wdata[HALF_W-1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CTRL: reg_rdata[CTRL_W-1:0] = st_q.ctrl;
            A_IEN:  reg_rdata[NDEV-1:0]   = st_q.idle_en;
            A_TEN:  reg_rdata[NDEV-1:0]   = st_q.trap_en;
            A_STAT: begin
                reg_rdata[NDEV-1:0]         = st_q.idle_st;
                reg_rdata[ST_GIDLE]         = st_q.g_idle;
                reg_rdata[ST_TRAP0 +: NDEV] = st_q.trap_st;
                reg_rdata[ST_GTRAP]         = st_q.g_trap;
            end
            default: ;
        endcase
        for (int i = 0; i < NDEV; i++) begin
            if (reg_addr == A_WIN0 + REG_AW'(i)) begin
                reg_rdata = {HALF_W'(st_q.size[i]), HALF_W'(st_q.base[i])};
            end
            if (reg_addr == A_RLD0 + REG_AW'(i)) begin
                reg_rdata = {HALF_W'(cnt[i]), HALF_W'(st_q.reload[i])};
            end
        end
    end
endmodule

// File: rtl/pidle_trap_chk.sv
`timescale 1ns/1ps
module pidle_trap_chk #(
    parameter int NDEV = 6,
    parameter int TW   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    tick,
    input logic                    smi,
    input logic                    freeze,
    input logic                    iirq,
    input logic                    tirq,
    input logic                    gidle,
    input logic [NDEV-1:0]         ien,
    input logic [NDEV-1:0]         ten,
    input logic [NDEV-1:0]         ist,
    input logic [NDEV-1:0]         tst,
    input logic [NDEV-1:0]         hit,
    input logic [NDEV-1:0]         wrl,
    input logic [NDEV-1:0][TW-1:0] cnt,
    input logic [NDEV-1:0][TW-1:0] rel
);
    for (genvar g = 0; g < NDEV; g++) begin : g_chk
        // R2
        frz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (freeze && !hit[g] && !wrl[g]) |=> $stable(cnt[g]));

        // R3
        hit_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && !wrl[g]) |=> (cnt[g] == $past(rel[g])));

        // R5
        expiry_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ien[g] && !freeze && tick && cnt[g] == TW'(1) && !hit[g] && !wrl[g])
            |=> (cnt[g] == '0 && ist[g] && gidle));

        // R5
        zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt[g] == '0 && !hit[g] && !wrl[g]) |=> (cnt[g] == '0));

        // R7
        trap_smi_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && ten[g] && tirq) |-> smi);

        // R9
        no_trap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && !ten[g] && !tst[g]) |=> !tst[g]);
    end

    // R6
    smi_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!iirq && !tirq) |-> !smi);
endmodule

bind pidle_trap_unit pidle_trap_chk #(.NDEV(NDEV), .TW(TW)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick),
    .smi    (smi),
    .freeze (st_q.ctrl.freeze),
    .iirq   (st_q.ctrl.idle_irq_en),
    .tirq   (st_q.ctrl.trap_irq_en),
    .gidle  (st_q.g_idle),
    .ien    (st_q.idle_en),
    .ten    (st_q.trap_en),
    .ist    (st_q.idle_st),
    .tst    (st_q.trap_st),
    .hit    (hit),
    .wrl    (wr_rld),
    .cnt    (cnt),
    .rel    (st_q.reload)
);

// File: tb/sim_pidle_trap_unit.sv
`timescale 1ns/1ps
module sim_pidle_trap_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        io_valid = 1'b0;
    logic [15:0] io_addr = '0;
    logic        reg_wr = 1'b0;
    logic [4:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        smi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    pidle_trap_unit u0 (
        .clk(clk), .rst_n(rst_n), .tick(tick), .io_valid(io_valid), .io_addr(io_addr),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .smi(smi)
    );

    // reference model state
    logic [15:0] m_base [6];
    logic [15:0] m_size [6];
    logic [15:0] m_rel  [6];
    logic [15:0] m_cnt  [6];
    logic [2:0]  m_ctrl;
    logic [5:0]  m_ien, m_ten, m_ist, m_tst;
    logic        m_gi, m_gt;

    function automatic logic m_hit(int d, logic v, logic [15:0] a);
        return v && (m_size[d] != 0) && (a >= m_base[d]) &&
               ((32'(a) - 32'(m_base[d])) < 32'(m_size[d]));
    endfunction

    function automatic logic [31:0] m_rd(logic [4:0] a);
        logic [31:0] r = '0;
        if (a == 0) r[2:0] = m_ctrl;
        if (a == 1) r[5:0] = m_ien;
        if (a == 2) r[5:0] = m_ten;
        if (a == 3) begin
            r[5:0] = m_ist; r[8] = m_gi; r[21:16] = m_tst; r[24] = m_gt;
        end
        for (int i = 0; i < 6; i++) begin
            if (a == 5'(8 + i))  r = {m_size[i], m_base[i]};
            if (a == 5'(16 + i)) r = {m_cnt[i], m_rel[i]};
        end
        return r;
    endfunction

    function automatic logic m_smi();
        logic tn = 1'b0;
        for (int i = 0; i < 6; i++) tn |= m_hit(i, io_valid, io_addr) && m_ten[i];
        return (m_ctrl[1] && (m_gi || (|m_ist))) || (m_ctrl[2] && (m_gt || (|m_tst) || tn));
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 6; i++) begin
            m_base[i] = '0; m_size[i] = '0; m_rel[i] = '0; m_cnt[i] = '0;
        end
        m_ctrl = '0; m_ien = '0; m_ten = '0; m_ist = '0; m_tst = '0; m_gi = 0; m_gt = 0;
    endtask

    task automatic m_step();
        logic [5:0] h, ex;
        ex = '0;
        for (int i = 0; i < 6; i++) h[i] = m_hit(i, io_valid, io_addr);
        for (int i = 0; i < 6; i++) begin
            if (reg_wr && reg_addr == 5'(16 + i)) m_cnt[i] = reg_wdata[15:0];
            else if (h[i]) m_cnt[i] = m_rel[i];
            else if (tick && m_ien[i] && !m_ctrl[0] && m_cnt[i] != 0) begin
                m_cnt[i] = m_cnt[i] - 1;
                if (m_cnt[i] == 0) ex[i] = 1'b1;
            end
        end
        if (reg_wr && reg_addr == 3) begin
            m_ist &= ~reg_wdata[5:0]; m_tst &= ~reg_wdata[21:16];
            if (reg_wdata[8])  m_gi = 0;
            if (reg_wdata[24]) m_gt = 0;
        end
        m_ist |= ex; m_tst |= (h & m_ten);
        if (|ex) m_gi = 1;
        if (|(h & m_ten)) m_gt = 1;
        if (reg_wr) begin
            if (reg_addr == 0) m_ctrl = reg_wdata[2:0];
            if (reg_addr == 1) m_ien = reg_wdata[5:0];
            if (reg_addr == 2) m_ten = reg_wdata[5:0];
            for (int i = 0; i < 6; i++) begin
                if (reg_addr == 5'(8 + i)) begin
                    m_base[i] = reg_wdata[15:0]; m_size[i] = reg_wdata[31:16];
                end
                if (reg_addr == 5'(16 + i)) m_rel[i] = reg_wdata[15:0];
            end
        end
    endtask

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one clock: edge, model update, compare away from edge
    task automatic cyc();
        @(posedge clk);
        m_step();
        @(negedge clk);
        chk("R2 R3 R4 R5 R8 R9", "model rdata", reg_rdata, m_rd(reg_addr));
        chk("R6 R7", "model smi", 32'(smi), 32'(m_smi()));
    endtask

    task automatic idle_inputs();
        tick = 0; io_valid = 0; reg_wr = 0;
    endtask

    task automatic wr(logic [4:0] a, logic [31:0] d);
        idle_inputs(); reg_wr = 1; reg_addr = a; reg_wdata = d;
        cyc();
        reg_wr = 0;
    endtask

    task automatic ticks(int n);
        idle_inputs(); tick = 1;
        for (int k = 0; k < n; k++) cyc();
        tick = 0;
    endtask

    task automatic access(logic [15:0] a, logic tk);
        idle_inputs(); io_valid = 1; io_addr = a; tick = tk;
        cyc();
        io_valid = 0; tick = 0;
    endtask

    task automatic rd(logic [4:0] a, output logic [31:0] d);
        reg_addr = a; #1; d = reg_rdata;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_0042));
        m_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int a = 0; a < 32; a++) begin
            rd(5'(a), v);
            chk("R1", "reset rdata", v, 32'h0);
        end
        chk("R1", "reset smi", 32'(smi), 32'h0);

        // windows: base in 15:0, size in 31:16
        wr(8,  32'h0008_0100);
        wr(9,  32'h0010_0220);
        wr(10, 32'h0008_03F8);
        wr(11, 32'h0001_0400);
        wr(12, 32'h0010_FFF0);
        wr(13, 32'h0000_0500);
        wr(1, 32'h1);

        // R4 reload write loads count
        wr(16, 32'd5);
        rd(16, v); chk("R4", "reload write", v, 32'h0005_0005);

        // R2 count and freeze
        ticks(2);
        rd(16, v); chk("R2", "two ticks", v, 32'h0003_0005);
        wr(0, 32'h1);
        ticks(3);
        rd(16, v); chk("R2", "frozen", v, 32'h0003_0005);

        // R3 window boundaries and collision with tick
        access(16'h0108, 1'b0);
        rd(16, v); chk("R3", "one past window", v, 32'h0003_0005);
        access(16'h0107, 1'b0);
        rd(16, v); chk("R3", "last address reloads", v, 32'h0005_0005);
        wr(0, 32'h2);
        access(16'h0100, 1'b1);
        rd(16, v); chk("R3", "hit beats tick", v, 32'h0005_0005);

        // R5 expiry timing, R6 idle interrupt
        ticks(4);
        rd(3, v);  chk("R5", "no status before zero", v, 32'h0);
        chk("R6", "smi low before expiry", 32'(smi), 32'h0);
        ticks(1);
        rd(3, v);  chk("R5", "status at expiry", v, 32'h0000_0101);
        rd(16, v); chk("R5", "count zero", v, 32'h0000_0005);
        chk("R6", "smi on expiry", 32'(smi), 32'h1);
        ticks(3);
        rd(16, v); chk("R5", "stays at zero", v, 32'h0000_0005);
        wr(0, 32'h0);
        chk("R6", "smi gated off", 32'(smi), 32'h0);
        wr(0, 32'h2);
        chk("R6", "smi gated on", 32'(smi), 32'h1);

        // R8 write-one-to-clear
        wr(3, 32'h0);
        rd(3, v); chk("R8", "zero write no effect", v, 32'h0000_0101);
        wr(3, 32'h0000_0101);
        rd(3, v); chk("R8", "cleared", v, 32'h0);
        chk("R8", "smi falls", 32'(smi), 32'h0);

        // R7 trap synchronous interrupt
        wr(2, 32'h2);
        wr(0, 32'h4);
        idle_inputs(); io_valid = 1; io_addr = 16'h022F; #1;
        chk("R7", "smi same cycle", 32'(smi), 32'h1);
        cyc(); io_valid = 0;
        rd(3, v); chk("R7", "trap status", v, 32'h0102_0000);

        // R9 hit without trap enable
        access(16'h03FA, 1'b0);
        rd(3, v); chk("R9", "no trap status", v, 32'h0102_0000);

        // R8 set beats clear in the same cycle
        idle_inputs(); reg_wr = 1; reg_addr = 3; reg_wdata = 32'h0002_0000;
        io_valid = 1; io_addr = 16'h0220;
        cyc(); idle_inputs();
        rd(3, v); chk("R8", "set wins over clear", v, 32'h0102_0000);
        wr(3, 32'h0102_0000);
        rd(3, v); chk("R8", "trap cleared", v, 32'h0);
        chk("R8", "smi low after clear", 32'(smi), 32'h0);

        // R3 size zero never matches
        wr(1, 32'h21);
        wr(21, 32'd7);
        ticks(2);
        access(16'h0500, 1'b1);
        rd(21, v); chk("R3", "size zero no hit", v, 32'h0004_0007);

        // random phase
        wr(3, 32'h0103_003F);
        wr(2, 32'h0A);
        wr(1, 32'h3F);
        wr(0, 32'h6);
        for (int d = 0; d < 6; d++) wr(5'(16 + d), 32'(3 + d));
        for (int n = 0; n < 4000; n++) begin
            int dv, off;
            dv  = int'($urandom % 6);
            off = int'($urandom % (32'(m_size[dv]) + 4)) - 2;
            tick      = ($urandom % 2) == 0;
            io_valid  = ($urandom % 4) == 0;
            io_addr   = m_base[dv] + 16'(off);
            reg_wr    = ($urandom % 12) == 0;
            reg_wdata = $urandom;
            case ($urandom % 6)
                0: begin reg_addr = 0; reg_wdata = {29'h0, 2'($urandom), ($urandom % 5) == 0}; end
                1: reg_addr = 1;
                2: reg_addr = 2;
                3: reg_addr = 3;
                4: reg_addr = 5'(8 + dv);
                default: begin reg_addr = 5'(16 + dv); reg_wdata = 32'($urandom % 12); end
            endcase
            if (reg_wr && reg_addr == 5'(8 + dv)) reg_wr = 0;
            cyc();
        end
        idle_inputs();
        cyc();

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule